// File: doc/BRIEF.md
# Bitwise Truth-Table Logic Unit

This execution slice serves a 64-bit register-file processor. It takes one 32-bit instruction word per cycle, together with the operand values that have already been read from the register file. It recognises two instruction forms.

The ternary form applies an arbitrary three-input Boolean function to every bit position of three 64-bit operands. These are the current destination value (T), RA and RB. The function is given as an 8-entry truth table held in an immediate field. The binary form applies an arbitrary two-input Boolean function to RA and RB. Its 4-entry table is not encoded in the instruction: it is read at run time from one of the two low nibbles of a third register, RC.

The result, the destination register index, a valid flag and an optional condition summary are registered and appear one cycle after the instruction is presented. Register-file access, hazards and exceptions are handled elsewhere.

Top module: `lutlog_unit`

## Requirements
- R1: Instruction bits are numbered big-endian, so bit 0 is `in_insn[31]`. A ternary instruction has primary opcode bits 0-5 equal to `TERN_PO` (default 5) and bits 29-30 equal to `TERN_XO` (default 0). When such an instruction is presented with `in_valid` high, `out_valid` is high one cycle later. `out_rt` then holds bits 6-10, which is `in_insn[25:21]`.
- R2: For the ternary form, the truth table is bits 21-28, `in_insn[10:3]`. Table entry k is `in_insn[3+k]`. Each result bit i equals the entry at index {src_t[i], src_a[i], src_b[i]}, with src_t as the most significant index bit.
- R3: The ternary form expresses a bitwise multiplexer (T&A)|(~T&B) with table 0xCA. It expresses the compound T^(~A&(B|T)) with table 0xC2.
- R4: A binary instruction has primary opcode bits 0-5 equal to `BIN_PO` (default 4) and bits 27-31 (`in_insn[4:0]`) equal to `BIN_XO` (default 3). When such an instruction is presented with `in_valid` high, `out_valid` is high one cycle later, with `out_rt` from bits 6-10.
- R5: For the binary form, each result bit i equals table entry {src_a[i], src_b[i]}. Entry k is bit k of the selected nibble.
- R6: The binary nibble-select flag is bit 26 (`in_insn[5]`). When it is 0, the table is `src_c[3:0]` (big-endian bits 60:63). When it is 1, the table is `src_c[7:4]` (bits 56:59).
- R7: A ternary instruction with record bit 31 (`in_insn[0]`) set raises `out_rec_valid` one cycle later. `out_rec` is then {negative, positive, zero, so_in}, in bits 3..0, for the signed 64-bit result.
- R8: The binary form never raises `out_rec_valid`.
- R9: When `in_valid` is low, or the opcodes match neither form, the next cycle shows `out_valid` and `out_rec_valid` low and `out_rt`, `out_data` and `out_rec` at zero.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 32 | Instruction word |
| src_t | input | 64 | Current contents of the destination register |
| src_a | input | 64 | RA operand value |
| src_b | input | 64 | RB operand value |
| src_c | input | 64 | RC operand value (binary table source) |
| so_in | input | 1 | Overflow summary copied into the record |
| out_valid | output | 1 | Result is valid |
| out_rt | output | 5 | Destination register index |
| out_data | output | 64 | Result value |
| out_rec_valid | output | 1 | Condition summary is valid |
| out_rec | output | 4 | {negative, positive, zero, so_in} |

## Verification
The assertions take for granted that the default opcodes of the two forms differ, so that one word never decodes as both. They also assume that `in_valid` and the operands are stable across each rising edge. The bench drives every input on the falling edge and keeps the opcode parameters at their distinct defaults. Random words are drawn with opcode fields that either match a form exactly or are forced away from both, so that the assumption on distinct decodes always holds.

// File: rtl/lutlog_pkg.sv
package lutlog_pkg;

  localparam int unsigned XLEN = 64;
  localparam int unsigned ILEN = 32;
  localparam int unsigned RIDX = 5;
  localparam int unsigned T3W  = 8;
  localparam int unsigned T2W  = 4;
  localparam int unsigned RECW = 4;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_TERN = 2'd1,
    OPK_BIN  = 2'd2
  } opk_e;

  typedef struct packed {
    opk_e            kind;
    logic [RIDX-1:0] rt;
    logic [T3W-1:0]  tbl3;
    logic            hi_nib;
    logic            rec;
  } dec_t;

  // big-endian bit n of a 32-bit word maps to little-endian position
  function automatic int unsigned be(input int unsigned n);
    return ILEN - 1 - n;
  endfunction

  function automatic logic pick3(input logic [T3W-1:0] tbl,
                                 input logic t, input logic a, input logic b);
    return tbl[{t, a, b}];
  endfunction

  function automatic logic pick2(input logic [T2W-1:0] tbl,
                                 input logic a, input logic b);
    return tbl[{a, b}];
  endfunction

endpackage

// File: rtl/lutlog_decode.sv
module lutlog_decode
  import lutlog_pkg::*;
#(
  parameter logic [5:0] TERN_PO = 6'd5,
  parameter logic [1:0] TERN_XO = 2'd0,
  parameter logic [5:0] BIN_PO  = 6'd4,
  parameter logic [4:0] BIN_XO  = 5'd3
) (
  input  logic            vld,
  input  logic [ILEN-1:0] insn,
  output dec_t            dec
);
  localparam int unsigned PO_HI = be(0);
  localparam int unsigned PO_LO = be(5);
  localparam int unsigned RT_HI = be(6);
  localparam int unsigned RT_LO = be(10);
  localparam int unsigned TB_HI = be(21);
  localparam int unsigned TB_LO = be(28);
  localparam int unsigned TX_HI = be(29);
  localparam int unsigned TX_LO = be(30);
  localparam int unsigned RC_B  = be(31);
  localparam int unsigned NH_B  = be(26);
  localparam int unsigned BX_HI = be(27);
  localparam int unsigned BX_LO = be(31);

  logic tern_hit, bin_hit;

  assign tern_hit = vld && (insn[PO_HI:PO_LO] == TERN_PO) && (insn[TX_HI:TX_LO] == TERN_XO);
  assign bin_hit  = vld && (insn[PO_HI:PO_LO] == BIN_PO)  && (insn[BX_HI:BX_LO] == BIN_XO);

  always_comb begin
    dec        = '0;
    dec.rt     = insn[RT_HI:RT_LO];
    dec.tbl3   = insn[TB_HI:TB_LO];
    dec.hi_nib = insn[NH_B];
    if (tern_hit) begin
      dec.kind = OPK_TERN;
      dec.rec  = insn[RC_B];
    end else if (bin_hit) begin
      dec.kind = OPK_BIN;
    end else begin
      dec.kind = OPK_NONE;
    end
  end

  always_comb begin
    assert (!(tern_hit && bin_hit)) else $error("p_one_form_r1: both forms decoded");
  end

endmodule

// File: rtl/lutlog_eval.sv
module lutlog_eval
  import lutlog_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  dec_t         dec,
  input  logic [W-1:0] t,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  logic [T2W-1:0] tbl2;
  logic [W-1:0]   y3, y2;

  assign tbl2 = dec.hi_nib ? c[2*T2W-1:T2W] : c[T2W-1:0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y3[i] = pick3(dec.tbl3, t[i], a[i], b[i]);
    assign y2[i] = pick2(tbl2, a[i], b[i]);
  end

  always_comb begin
    unique case (dec.kind)
      OPK_TERN: y = y3;
      OPK_BIN:  y = y2;
      default:  y = '0;
    endcase
  end

  always_comb begin
    if (dec.kind == OPK_TERN && dec.tbl3 == 8'hAA)
      assert (y == b) else $error("p_tbl_copy_b_r2: table AA must copy RB");
  end

endmodule

// File: rtl/lutlog_record.sv
module lutlog_record
  import lutlog_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0]    val,
  input  logic            so,
  output logic [RECW-1:0] rec
);
  logic neg, zer, pos;
  assign neg = val[W-1];
  assign zer = (val == '0);
  assign pos = !neg && !zer;
  assign rec = {neg, pos, zer, so};
endmodule

// File: rtl/lutlog_unit.sv
module lutlog_unit
  import lutlog_pkg::*;
#(
  parameter logic [5:0] TERN_PO = 6'd5,
  parameter logic [1:0] TERN_XO = 2'd0,
  parameter logic [5:0] BIN_PO  = 6'd4,
  parameter logic [4:0] BIN_XO  = 5'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_insn,
  input  logic [63:0]      src_t,
  input  logic [63:0]      src_a,
  input  logic [63:0]      src_b,
  input  logic [63:0]      src_c,
  input  logic             so_in,
  output logic             out_valid,
  output logic [4:0]       out_rt,
  output logic [63:0]      out_data,
  output logic             out_rec_valid,
  output logic [3:0]       out_rec
);
  dec_t            dec;
  logic [XLEN-1:0] res;
  logic [RECW-1:0] rec;
  logic            hit;
  logic            rec_hit;

  lutlog_decode #(
    .TERN_PO(TERN_PO), .TERN_XO(TERN_XO), .BIN_PO(BIN_PO), .BIN_XO(BIN_XO)
  ) u_dec (
    .vld(in_valid), .insn(in_insn), .dec(dec)
  );

  lutlog_eval #(.W(XLEN)) u_eval (
    .dec(dec), .t(src_t), .a(src_a), .b(src_b), .c(src_c), .y(res)
  );

  lutlog_record #(.W(XLEN)) u_rec (
    .val(res), .so(so_in), .rec(rec)
  );

  assign hit     = (dec.kind != OPK_NONE);
  assign rec_hit = (dec.kind == OPK_TERN) && dec.rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_rt        <= '0;
      out_data      <= '0;
      out_rec_valid <= 1'b0;
      out_rec       <= '0;
    end else begin
      out_valid     <= hit;
      out_rt        <= hit ? dec.rt : '0;
      out_data      <= res;
      out_rec_valid <= rec_hit;
      out_rec       <= rec_hit ? rec : '0;
    end
  end

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_rec_valid && out_data == '0));

  p_rec_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_rec_valid |-> out_valid);

  p_rec_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_rec_valid |-> ($countones(out_rec[3:1]) == 1));

  p_ones_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == OPK_TERN && in_insn[10:3] == 8'hFF) |=> (out_data == '1));

  p_high_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == OPK_BIN && in_insn[5] && src_c[7:4] == 4'h0) |=> (out_data == '0 && out_valid));

endmodule

// File: tb/lutlog_unit_tb_top.sv
module lutlog_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [63:0] src_t = '0, src_a = '0, src_b = '0, src_c = '0;
  logic        so_in = 1'b0;
  logic        out_valid, out_rec_valid;
  logic [4:0]  out_rt;
  logic [63:0] out_data;
  logic [3:0]  out_rec;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lutlog_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .src_t(src_t), .src_a(src_a), .src_b(src_b), .src_c(src_c), .so_in(so_in),
    .out_valid(out_valid), .out_rt(out_rt), .out_data(out_data),
    .out_rec_valid(out_rec_valid), .out_rec(out_rec)
  );

  function automatic logic [31:0] mk_tern(input logic [4:0] rt, input logic [7:0] tb, input logic rc);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'd5; w[25:21] = rt; w[20:16] = 5'd1; w[15:11] = 5'd2;
    w[10:3] = tb; w[2:1] = 2'd0; w[0] = rc;
    return w;
  endfunction

  function automatic logic [31:0] mk_bin(input logic [4:0] rt, input logic nh);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'd4; w[25:21] = rt; w[20:16] = 5'd3; w[15:11] = 5'd4;
    w[10:6] = 5'd5; w[5] = nh; w[4:0] = 5'd3;
    return w;
  endfunction

  // reference: build each result bit by expanding the table as a sum of minterms
  function automatic logic [63:0] ref3(input logic [7:0] tb, input logic [63:0] t, a, b);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 8; k++) begin
      logic [63:0] mt;
      mt = (k[2] ? t : ~t) & (k[1] ? a : ~a) & (k[0] ? b : ~b);
      if (tb[k]) r |= mt;
    end
    return r;
  endfunction

  function automatic logic [63:0] ref2(input logic [3:0] tb, input logic [63:0] a, b);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [63:0] mt;
      mt = (k[1] ? a : ~a) & (k[0] ? b : ~b);
      if (tb[k]) r |= mt;
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_rec(input logic [63:0] v, input logic so);
    return {$signed(v) < 0, $signed(v) > 0, v == 64'd0, so};
  endfunction

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] w);
    @(negedge clk);
    in_valid = v; in_insn = w;
    @(posedge clk); #2;
  endtask

  task automatic run_tern(input string tag, input logic [4:0] rt, input logic [7:0] tb, input logic rc);
    logic [63:0] e;
    issue(1'b1, mk_tern(rt, tb, rc));
    e = ref3(tb, src_t, src_a, src_b);
    chk({tag, " valid"}, {127'd0, out_valid}, 128'd1);
    chk({tag, " rt"}, {123'd0, out_rt}, {123'd0, rt});
    chk({tag, " data"}, {64'd0, out_data}, {64'd0, e});
    chk({tag, " recv"}, {127'd0, out_rec_valid}, {127'd0, rc});
    if (rc) chk({tag, " R7 rec"}, {124'd0, out_rec}, {124'd0, ref_rec(e, so_in)});
  endtask

  task automatic run_bin(input string tag, input logic [4:0] rt, input logic nh);
    logic [63:0] e;
    issue(1'b1, mk_bin(rt, nh));
    e = ref2(nh ? src_c[7:4] : src_c[3:0], src_a, src_b);
    chk({tag, " valid"}, {127'd0, out_valid}, 128'd1);
    chk({tag, " rt"}, {123'd0, out_rt}, {123'd0, rt});
    chk({tag, " data"}, {64'd0, out_data}, {64'd0, e});
    chk({tag, " R8 no record"}, {127'd0, out_rec_valid}, 128'd0);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " valid"}, {127'd0, out_valid}, 128'd0);
    chk({tag, " recv"}, {127'd0, out_rec_valid}, 128'd0);
    chk({tag, " data"}, {64'd0, out_data}, 128'd0);
    chk({tag, " rt/rec"}, {119'd0, out_rt, out_rec}, 128'd0);
  endtask

  initial begin
    #1_600_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #3;
    chk_idle("R10 reset");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: all immediates with random operands
    for (int k = 0; k < 256; k++) begin
      src_t = r64(); src_a = r64(); src_b = r64();
      run_tern("R2 sweep", 5'($urandom()), 8'(k), 1'b0);
    end

    // R3 directed: mux and compound
    src_t = 64'hFFFF0000_F0F0AAAA; src_a = 64'h12345678_9ABCDEF0; src_b = 64'h0FEDCBA9_87654321;
    run_tern("R3 mux", 5'd7, 8'hCA, 1'b0);
    chk("R3 mux form", {64'd0, out_data}, {64'd0, (src_t & src_a) | (~src_t & src_b)});
    run_tern("R3 compound", 5'd8, 8'hC2, 1'b0);
    chk("R3 compound form", {64'd0, out_data}, {64'd0, src_t ^ (~src_a & (src_b | src_t))});

    // R1 rt field corners
    run_tern("R1 rt31", 5'd31, 8'h96, 1'b0);
    run_tern("R1 rt0", 5'd0, 8'h96, 1'b0);

    // R7 record: negative, zero, positive, and so copy
    so_in = 1'b1;
    src_t = 64'h8000_0000_0000_0000;
    run_tern("R7 neg", 5'd3, 8'hF0, 1'b1);
    so_in = 1'b0;
    run_tern("R7 zero", 5'd3, 8'h00, 1'b1);
    src_t = 64'd1;
    run_tern("R7 pos", 5'd3, 8'hF0, 1'b1);
    for (int k = 0; k < 40; k++) begin
      src_t = r64(); src_a = r64(); src_b = r64(); so_in = 1'($urandom());
      run_tern("R7 rand", 5'($urandom()), 8'($urandom()), 1'b1);
    end

    // R4/R5/R6 binary form, both nibble selections
    for (int k = 0; k < 16; k++) begin
      src_a = r64(); src_b = r64();
      src_c = {r64() & ~64'hFF} | {56'd0, 4'($urandom()), 4'(k)};
      run_bin("R5 R6 lo", 5'($urandom()), 1'b0);
      src_c = {r64() & ~64'hFF} | {56'd0, 4'(k), 4'($urandom())};
      run_bin("R5 R6 hi", 5'($urandom()), 1'b1);
    end
    src_a = 64'hFF00FF00_FF00FF00; src_b = 64'hF0F0F0F0_F0F0F0F0;
    src_c = 64'h0000_0000_0000_0086;
    run_bin("R6 nh0 xor", 5'd9, 1'b0);
    chk("R6 nh0 xor form", {64'd0, out_data}, {64'd0, src_a ^ src_b});
    run_bin("R6 nh1 and", 5'd10, 1'b1);
    chk("R6 nh1 and form", {64'd0, out_data}, {64'd0, src_a & src_b});
    run_bin("R4 rt31", 5'd31, 1'b0);

    // R9: invalid strobe, wrong opcodes
    issue(1'b0, mk_tern(5'd4, 8'hFF, 1'b1));
    chk_idle("R9 strobe low");
    issue(1'b1, mk_tern(5'd4, 8'hFF, 1'b1) | 32'h0000_0002);
    chk_idle("R9 tern bad xo");
    issue(1'b1, mk_bin(5'd4, 1'b0) ^ 32'h0000_0001);
    chk_idle("R9 bin bad xo");
    for (int k = 0; k < 30; k++) begin
      logic [31:0] w;
      w = $urandom();
      if (w[31:26] == 6'd4 || w[31:26] == 6'd5) w[31:26] = 6'd9;
      src_t = r64(); src_a = r64(); src_b = r64(); src_c = r64();
      issue(1'b1, w);
      chk_idle("R9 bad po");
    end

    // R10: reset mid-stream
    src_t = r64();
    issue(1'b1, mk_tern(5'd6, 8'hF0, 1'b1));
    @(negedge clk); rst_n = 1'b0; #1;
    chk_idle("R10 reset again");
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
    @(posedge clk); #2;
    chk_idle("R10 after reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule